// File: doc/BRIEF.md
# Nibble-Serial SRAM Access Bridge

This bridge gives a host with very few spare pins sequential access to a byte-wide asynchronous SRAM. The host has a 4-bit data path and three control lines: a clear line, a step line and a direction line. The bridge keeps an internal position counter. Bit 0 of the counter selects a nibble within the current byte, and the upper bits form the SRAM word address. Because of this, a byte takes two step pulses, and no address pins are needed for sequential work.

In write mode the host presents the high nibble and then the low nibble, with one step pulse for each. The bridge keeps the first nibble. When the second nibble arrives, it strobes the whole byte into the SRAM in a single cycle. In read mode the bridge enables the SRAM output while the position is even and latches the byte. It then presents the high nibble and then the low nibble from that latched copy. The host control lines are asynchronous, so the bridge synchronises them and edge-detects the step line.

Top module: `nibble_sram_bridge`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is active, or for as long as the synchronised host clear is high, the position is forced to 0 and any held nibble is dropped. After reset, sram_addr=0, sram_we_n=1, sram_oe_n=1, sram_ce_n=1 and host_nib_oe=0.
- R2: Each rising edge of host_step moves the position forward by exactly one. The edge takes effect 3 clock edges after it is sampled. Holding host_step high for any length of time gives only one advance.
- R3: Outside a write strobe, sram_addr equals bits [POS_W-1:1] of the position.
- R4: In write mode (host_rd=0), a step at an even position stores host_nib_i as the high nibble. A step at the following odd position pulses sram_we_n and sram_ce_n low for exactly one cycle. During that pulse, sram_dout={high,low} and sram_addr is the byte address of that pair.
- R5: sram_oe_n (with sram_ce_n) is low only in read mode (host_rd=1), at an even position, and never together with sram_we_n low. The SRAM byte is latched on those cycles.
- R6: In read mode host_nib_oe=1. host_nib_o carries bits [7:4] of the latched byte at an even position and bits [3:0] at an odd position.
- R7: Any change of the synchronised direction discards a held high nibble. No write strobe is issued for that byte.
- R8: In write mode host_nib_oe=0 and host_nib_o=0.
- R9: The position wraps from all ones to 0 on the next step, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_clr | input | 1 | Asynchronous host clear of the position |
| host_step | input | 1 | Asynchronous host advance line; its rising edge counts |
| host_rd | input | 1 | Direction: 1 read, 0 write |
| host_nib_i | input | 4 | Nibble from host |
| host_nib_o | output | 4 | Nibble to host |
| host_nib_oe | output | 1 | Host bus drive enable (read mode) |
| sram_addr | output | POS_W-1 | SRAM word address |
| sram_din | input | 8 | Byte read from SRAM |
| sram_dout | output | 8 | Byte to write to SRAM |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The bench goes after the following corner cases:

- **Long step pulse.** It holds the step line high for many cycles. A design that advances on level rather than edge would race through several nibbles.
- **Direction toggled mid-byte.** It flips direction after only the high nibble has been given, then completes the byte. A design that keeps the stale nibble would overwrite a byte whose contents are known.
- **Counter wrap.** It walks the counter through a full wrap. A design that saturates or mis-sizes the counter would fail to return to byte 0 and its high nibble.
- **Write ordering and read re-use.** Writes followed by reads show whether the high nibble really goes first. A design that swaps the nibbles or re-reads on the odd half would differ from the reference model on some cycle.

// File: rtl/bridge_pkg.sv
// Shared types for the nibble-serial SRAM bridge.
package bridge_pkg;
    typedef logic [3:0] nib_t;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/bridge_sync.sv
// bridge_sync: brings one asynchronous host line into the clock domain.
// Outputs the settled level, a one-cycle rising-edge pulse and a
// one-cycle change pulse. Assumes the line is held for more than
// STAGES+1 clock cycles between transitions.
module bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic chg
);
    logic [STAGES-1:0] shf;
    logic              prev;

    // shift the raw line through the synchroniser and keep one older copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf  <= '0;
            prev <= 1'b0;
        end else begin
            shf  <= {shf[STAGES-2:0], din};
            prev <= shf[STAGES-1];
        end
    end

    assign lvl  = shf[STAGES-1];
    assign rise = lvl & ~prev;
    assign chg  = lvl ^ prev;
endmodule

// File: rtl/bridge_pos_ctr.sv
// bridge_pos_ctr: position counter. Bit 0 selects the nibble and the upper
// bits form the SRAM word address. The counter is cleared by a level and
// advanced by an edge pulse, and it wraps silently.
module bridge_pos_ctr #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [POS_W-1:0] pos
);
    // clear has priority over advance
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pos <= '0;
        else if (adv)      pos <= pos + 1'b1;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> pos == '0); // R1
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!clr && adv) |=> pos == $past(pos) + 1'b1); // R2
    AST_NO_DRIFT: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !adv) |=> $stable(pos)); // R2
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (!clr && adv && pos == '1) |=> pos == '0); // R9
endmodule

// File: rtl/bridge_wr_pack.sv
// bridge_wr_pack: builds a byte from two host nibbles, high nibble first,
// and issues a single-cycle write request carrying the byte and its address.
// Assumes the host nibble is stable whenever the step pulse is detected.
module bridge_wr_pack
    import bridge_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          dir_chg,
    input  logic          rd_mode,
    input  logic          adv,
    input  logic          pos_lsb,
    input  logic [AW-1:0] pos_addr,
    input  nib_t          nib_in,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output byte_t         wr_data
);
    nib_t hold;
    logic hold_vld;

    // collect high nibble, fire write on the low nibble if a high one is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_vld <= 1'b0;
            wr_go    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_go <= 1'b0;
            if (clr || dir_chg) begin
                hold_vld <= 1'b0;
            end else if (adv && !rd_mode) begin
                if (!pos_lsb) begin
                    hold     <= nib_in;
                    hold_vld <= 1'b1;
                end else begin
                    hold_vld <= 1'b0;
                    if (hold_vld) begin
                        wr_go   <= 1'b1;
                        wr_addr <= pos_addr;
                        wr_data <= {hold, nib_in};
                    end
                end
            end
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !wr_go); // R4
    AST_WE_AFTER_ODD: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_go) |-> $past(pos_lsb)); // R4
    AST_DIR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n) dir_chg |=> !wr_go); // R7
endmodule

// File: rtl/bridge_rd_hold.sv
// bridge_rd_hold: enables the SRAM output while in read mode at an even
// position and latches the byte. The latched byte supplies both nibbles,
// so the SRAM is read once per byte.
module bridge_rd_hold
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_mode,
    input  logic  pos_lsb,
    input  logic  wr_busy,
    input  byte_t sram_byte,
    output logic  oe,
    output nib_t  nib_out
);
    byte_t latched;

    assign oe = rd_mode & ~pos_lsb & ~wr_busy;

    // capture the SRAM byte while the output is enabled
    always_ff @(posedge clk) begin
        if (!rst_n)  latched <= '0;
        else if (oe) latched <= sram_byte;
    end

    // steer high nibble at even position, low nibble at odd position
    always_comb begin
        if (!rd_mode)     nib_out = '0;
        else if (pos_lsb) nib_out = latched[3:0];
        else              nib_out = latched[7:4];
    end

    AST_ODD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (pos_lsb && $past(pos_lsb)) |-> $stable(latched)); // R5
endmodule

// File: rtl/nibble_sram_bridge.sv
// nibble_sram_bridge: top level. It synchronises the three host control
// lines, keeps the position counter and joins the write packer and the
// read holder to the SRAM strobes. The SRAM is assumed to be asynchronous
// and to settle within one clock.
module nibble_sram_bridge
    import bridge_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_clr,
    input  logic             host_step,
    input  logic             host_rd,
    input  logic [3:0]       host_nib_i,
    output logic [3:0]       host_nib_o,
    output logic             host_nib_oe,
    output logic [POS_W-2:0] sram_addr,
    input  logic [7:0]       sram_din,
    output logic [7:0]       sram_dout,
    output logic             sram_ce_n,
    output logic             sram_we_n,
    output logic             sram_oe_n
);
    localparam int AW = POS_W - 1;

    logic clr_s, clr_rise, clr_chg;
    logic stp_s, stp_rise, stp_chg;
    logic rd_s, rd_rise, rd_chg;
    logic [POS_W-1:0] pos;
    logic          wr_go;
    logic [AW-1:0] wr_addr;
    byte_t         wr_data;
    logic          oe;
    nib_t          nib_rd;

    bridge_sync u_sync_clr (.clk(clk), .rst_n(rst_n), .din(host_clr),
                            .lvl(clr_s), .rise(clr_rise), .chg(clr_chg));
    bridge_sync u_sync_stp (.clk(clk), .rst_n(rst_n), .din(host_step),
                            .lvl(stp_s), .rise(stp_rise), .chg(stp_chg));
    bridge_sync u_sync_rd  (.clk(clk), .rst_n(rst_n), .din(host_rd),
                            .lvl(rd_s), .rise(rd_rise), .chg(rd_chg));

    bridge_pos_ctr #(.POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(clr_s), .adv(stp_rise), .pos(pos));

    bridge_wr_pack #(.AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(clr_s), .dir_chg(rd_chg),
        .rd_mode(rd_s), .adv(stp_rise), .pos_lsb(pos[0]),
        .pos_addr(pos[POS_W-1:1]), .nib_in(host_nib_i),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data));

    bridge_rd_hold u_rd (
        .clk(clk), .rst_n(rst_n), .rd_mode(rd_s), .pos_lsb(pos[0]),
        .wr_busy(wr_go), .sram_byte(sram_din), .oe(oe), .nib_out(nib_rd));

    // SRAM side: the write address overrides the counter during the strobe
    always_comb begin
        sram_addr = wr_go ? wr_addr : pos[POS_W-1:1];
        sram_dout = wr_data;
        sram_we_n = ~wr_go;
        sram_oe_n = ~oe;
        sram_ce_n = ~(wr_go | oe);
    end

    // host side: the bus is driven only in read mode
    assign host_nib_oe = rd_s;
    assign host_nib_o  = nib_rd;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!sram_we_n && !sram_oe_n)); // R5
    AST_CE_COVERS: assert property (@(posedge clk) disable iff (!rst_n) (!sram_we_n || !sram_oe_n) |-> !sram_ce_n); // R4
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !host_nib_oe |-> host_nib_o == 4'h0); // R8
    AST_OE_READONLY: assert property (@(posedge clk) disable iff (!rst_n) !sram_oe_n |-> host_nib_oe); // R5
endmodule

// File: tb/nibble_sram_bridge_bench.sv
// Bench: a behavioural reference model is compared on every clock, and
// directed checks are added for the corner cases.
module nibble_sram_bridge_bench;
    localparam int BPOS  = 10;
    localparam int BYTES = 1 << (BPOS - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_clr = 1'b0, host_step = 1'b0, host_rd = 1'b0;
    logic [3:0] host_nib_i = 4'h0;
    logic [3:0] host_nib_o;
    logic host_nib_oe;
    logic [BPOS-2:0] sram_addr;
    logic [7:0] sram_din, sram_dout;
    logic sram_ce_n, sram_we_n, sram_oe_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_sram_bridge #(.POS_W(BPOS)) u_nibble_sram_bridge (
        .clk(clk), .rst_n(rst_n), .host_clr(host_clr), .host_step(host_step),
        .host_rd(host_rd), .host_nib_i(host_nib_i), .host_nib_o(host_nib_o),
        .host_nib_oe(host_nib_oe), .sram_addr(sram_addr), .sram_din(sram_din),
        .sram_dout(sram_dout), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n));

    // SRAM model
    logic [7:0] mem [BYTES];
    logic [7:0] exp_mem [BYTES];
    initial for (int i = 0; i < BYTES; i++) begin
        mem[i] = 8'((i * 37 + 5) & 255);
        exp_mem[i] = mem[i];
    end
    assign sram_din = mem[sram_addr];
    always @(posedge clk) if (!sram_we_n && !sram_ce_n) mem[sram_addr] <= sram_dout;

    // behavioural reference model
    int m_pos = 0, m_waddr = 0, m_wdata = 0, m_byte = 0, m_hold = 0;
    bit m_hv = 0, m_wgo = 0;
    bit [1:0] q_stp = 0, q_clr = 0, q_rd = 0;
    bit m_stp_prev = 0, m_rd_prev = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos <= 0; m_waddr <= 0; m_wdata <= 0; m_byte <= 0; m_hold <= 0;
            m_hv <= 0; m_wgo <= 0; q_stp <= 0; q_clr <= 0; q_rd <= 0;
            m_stp_prev <= 0; m_rd_prev <= 0;
        end else begin
            bit edge_s, clr_l, rd_l, flip, rdok;
            edge_s = q_stp[1] && !m_stp_prev;
            clr_l  = q_clr[1];
            rd_l   = q_rd[1];
            flip   = rd_l != m_rd_prev;
            q_stp <= {q_stp[0], host_step};
            q_clr <= {q_clr[0], host_clr};
            q_rd  <= {q_rd[0], host_rd};
            m_stp_prev <= q_stp[1];
            m_rd_prev  <= q_rd[1];
            if (clr_l) m_pos <= 0;
            else if (edge_s) m_pos <= (m_pos + 1) % (1 << BPOS);
            m_wgo <= 0;
            if (m_wgo) exp_mem[m_waddr] <= 8'(m_wdata);
            rdok = rd_l && (m_pos % 2 == 0) && !m_wgo;
            if (rdok) m_byte <= exp_mem[m_pos / 2];
            if (clr_l || flip) m_hv <= 0;
            else if (edge_s && !rd_l) begin
                if (m_pos % 2 == 0) begin m_hold <= host_nib_i; m_hv <= 1; end
                else begin
                    m_hv <= 0;
                    if (m_hv) begin
                        m_wgo <= 1; m_waddr <= m_pos / 2;
                        m_wdata <= m_hold * 16 + host_nib_i;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        bit oe_e, rd_l;
        int a_e, n_e;
        rd_l = q_rd[1];
        oe_e = rd_l && (m_pos % 2 == 0) && !m_wgo;
        a_e  = m_wgo ? m_waddr : m_pos / 2;
        n_e  = !rd_l ? 0 : ((m_pos % 2) ? (m_byte & 15) : (m_byte >> 4));
        chk(sram_addr == a_e, "R3 addr", sram_addr, a_e);
        chk(sram_we_n == !m_wgo, "R4 we_n", sram_we_n, !m_wgo);
        if (m_wgo) chk(sram_dout == m_wdata, "R4 dout", sram_dout, m_wdata);
        chk(sram_oe_n == !oe_e, "R5 oe_n", sram_oe_n, !oe_e);
        chk(sram_ce_n == !(oe_e || m_wgo), "R5 ce_n", sram_ce_n, !(oe_e || m_wgo));
        chk(host_nib_oe == rd_l, "R6 R8 nib_oe", host_nib_oe, rd_l);
        chk(host_nib_o == n_e, "R6 R8 nib_o", host_nib_o, n_e);
    end

    task automatic pulse(input int hi = 3);
        host_step = 1'b1;
        repeat (hi) @(negedge clk);
        host_step = 1'b0;
        repeat (3) @(negedge clk);
    endtask
    task automatic put_nib(input logic [3:0] n);
        host_nib_i = n;
        pulse();
    endtask
    task automatic set_dir(input logic d);
        host_rd = d;
        repeat (4) @(negedge clk);
    endtask
    task automatic clear();
        host_clr = 1'b1;
        repeat (4) @(negedge clk);
        host_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask
    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_addr == 0, "R1 reset addr", sram_addr, 0);
        chk(sram_we_n && sram_oe_n && sram_ce_n, "R1 reset strobes",
            {sram_we_n, sram_oe_n, sram_ce_n}, 7);
        chk(host_nib_oe == 0, "R1 reset nib_oe", host_nib_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: write three bytes, high nibble first
        put_nib(4'hA); put_nib(4'h5);
        put_nib(4'h3); put_nib(4'hC);
        put_nib(4'hF); put_nib(4'h0);
        chk(mem[0] == 8'hA5, "R4 byte0", mem[0], 8'hA5);
        chk(mem[1] == 8'h3C, "R4 byte1", mem[1], 8'h3C);
        chk(mem[2] == 8'hF0, "R4 byte2", mem[2], 8'hF0);
        chk(host_nib_oe == 0 && host_nib_o == 0, "R8 write bus idle", host_nib_oe, 0);
        chk(sram_addr == 3, "R3 addr after six steps", sram_addr, 3);

        // R1: clear returns to byte 0
        clear();
        chk(sram_addr == 0, "R1 clear addr", sram_addr, 0);

        // R6: read back nibble by nibble
        set_dir(1'b1);
        chk(host_nib_o == 4'hA, "R6 hi nibble", host_nib_o, 4'hA);
        pulse();
        chk(host_nib_o == 4'h5, "R6 lo nibble", host_nib_o, 4'h5);
        pulse();
        chk(host_nib_o == 4'h3, "R6 next hi", host_nib_o, 4'h3);
        chk(sram_addr == 1, "R3 read addr", sram_addr, 1);

        // R2: a long step pulse advances only once
        clear();
        pulse(15);
        chk(host_nib_o == 4'h5, "R2 long pulse one step", host_nib_o, 4'h5);
        chk(sram_addr == 0, "R2 still byte0", sram_addr, 0);

        // R7: direction flip mid-byte discards held nibble
        clear();
        set_dir(1'b0);
        put_nib(4'h1);
        set_dir(1'b1);
        set_dir(1'b0);
        put_nib(4'h2);
        repeat (3) @(negedge clk);
        chk(mem[0] == 8'hA5, "R7 no write after flip", mem[0], 8'hA5);

        // R9: full wrap of the position
        clear();
        set_dir(1'b1);
        for (int k = 0; k < (1 << BPOS); k++) pulse();
        chk(sram_addr == 0, "R9 wrap addr", sram_addr, 0);
        chk(host_nib_o == 4'hA, "R9 wrap hi nibble", host_nib_o, 4'hA);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule